// File: doc/BRIEF.md
# Fast Offset Compensation Trigger Unit

This block runs a one-shot offset correction on one axis of a three-axis acceleration path. Software writes a control byte. The byte can clear all stored offsets, name one axis to compensate, and set three slow-compensation enable bits. When an axis is named, the unit looks up the target level for that axis (0 g, +1 g or -1 g) from a settings input. It stores target minus the current raw sample as the axis's 16-bit internal offset. It also keeps an 8-bit storage-format copy of that offset in the axis's offset register.

The control sequence is a five-state machine. `IDLE` accepts a write and latches it (transition *accept*). `EVAL` checks the ready flag, the range setting and the two error-enable inputs. From `EVAL` the machine moves to one of four places: `FAULT` (transition *reject*), `CLEAR` (transition *wipe*), `APPLY` (transition *compensate*), or straight back to `IDLE` (transition *settle*). `CLEAR` zeroes every offset and then goes either to `APPLY` (transition *chain*) or to `IDLE`. `APPLY` loads the selected axis and returns to `IDLE` (transition *done*). `FAULT` raises the error output for exactly one cycle and returns to `IDLE` (transition *recover*). A rejected write is not committed in any part.

Top module: `ofc_fast_comp`

## Requirements
- R1: After reset, all three internal offsets and all three 8-bit offset registers are zero, the slow-enable bits read zero, and `busy` and `err` are low.
- R2: Control byte layout: bit 7 is offset clear, bits [6:5] are the trigger (0 none, 1 X, 2 Y, 3 Z), and bits [2:0] are the slow-compensation enables for X, Y and Z. `ctl_rdata` returns the ready flag in bit 4 and the committed enables in bits [2:0]. All other bits read 0, and the clear and trigger bits are never retained.
- R3: `tgt_sel` holds two bits per axis: X in [1:0], Y in [3:2], Z in [5:4]. Code 1 means +1024 counts, code 2 means -1024 counts, and codes 0 and 3 mean 0.
- R4: On an accepted trigger with the ready flag set, the selected axis's offset becomes target minus that axis's raw sample, modulo 2^16. The other axes keep their values.
- R5: Each 8-bit offset register equals {offset[15], offset[9:3]} of its axis's internal offset.
- R6: A clear bit zeroes all offsets and offset registers. It takes effect before a trigger in the same write, so the triggered axis ends with its new value and the others end at zero.
- R7: With the ready flag clear, a non-zero trigger changes no offset. If `err_en_notready` is set, the write is rejected with an error. Otherwise the clear and enable fields still take effect.
- R8: With the ready flag set, a non-zero trigger and a range code other than 2 g (code 3), the write is rejected when `err_en_range` is set. When that check is off, compensation proceeds.
- R9: A rejected write pulses `err` high for exactly one cycle and changes no offset, offset register or enable bit.
- R10: `busy` is high from the cycle after an accepted write until the operation ends, at most three cycles. Writes presented while `busy` is high are ignored.
- R11: Offsets, offset registers and enable bits change only at the clock edge that ends a `busy` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| tgt_sel | input | 6 | Per-axis target codes |
| cal_ready | input | 1 | Compensation ready flag |
| range_sel | input | 4 | Current measurement range code |
| err_en_notready | input | 1 | Enable error on trigger while not ready |
| err_en_range | input | 1 | Enable error on trigger outside 2 g range |
| raw_x | input | 16 | Raw X sample, two's complement |
| raw_y | input | 16 | Raw Y sample, two's complement |
| raw_z | input | 16 | Raw Z sample, two's complement |
| busy | output | 1 | Operation in progress |
| err | output | 1 | One-cycle rejection pulse |
| ctl_rdata | output | 8 | Control register readback |
| off_x | output | 16 | X internal offset |
| off_y | output | 16 | Y internal offset |
| off_z | output | 16 | Z internal offset |
| offreg_x | output | 8 | X offset register |
| offreg_y | output | 8 | Y offset register |
| offreg_z | output | 8 | Z offset register |

## Verification
A state machine stuck outside `IDLE` shows up at once as `busy` staying high past three cycles, and later writes then have no effect. A wrong legality decision in `EVAL` shows up one cycle after the write, either as a missing or doubled `err` pulse, or as offsets that change when they should not. A wrong axis decode or target sign shows up on the offset outputs when `busy` falls. The clear-then-apply order is visible in the same cycle, through the value left on the triggered axis.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_CLEAR,
        ST_APPLY,
        ST_FAULT
    } ofc_state_e;

    localparam int CTL_W      = 8;
    localparam int CLR_BIT    = 7;
    localparam int TRIG_LO    = 5;
    localparam int TRIG_W     = 2;
    localparam int SLOW_W     = 3;
    localparam int RDY_BIT    = 4;
    localparam int TCODE_W    = 2;

    localparam logic [TCODE_W-1:0] TCODE_PLUS  = 2'd1;
    localparam logic [TCODE_W-1:0] TCODE_MINUS = 2'd2;

endpackage

// File: rtl/ofc_target_sel.sv
module ofc_target_sel #(
    parameter int OFF_W = 16,
    parameter int ONE_G = 1024
) (
    input  logic [ofc_pkg::TCODE_W-1:0] code,
    output logic [OFF_W-1:0]            target
);
    localparam logic [OFF_W-1:0] POS = OFF_W'(ONE_G);
    localparam logic [OFF_W-1:0] NEG = OFF_W'(-ONE_G);

    always_comb begin
        unique case (code)
            ofc_pkg::TCODE_PLUS:  target = POS;
            ofc_pkg::TCODE_MINUS: target = NEG;
            default:              target = '0;
        endcase
    end
endmodule

// File: rtl/ofc_axis_regs.sv
module ofc_axis_regs #(
    parameter int OFF_W  = 16,
    parameter int ST_W   = 8,
    parameter int ST_SHR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [OFF_W-1:0] target,
    input  logic [OFF_W-1:0] raw,
    output logic [OFF_W-1:0] off_q,
    output logic [ST_W-1:0]  store_q
);
    localparam int MAG_W = ST_W - 1;

    logic [OFF_W-1:0] diff;
    logic [ST_W-1:0]  packed_d;

    assign diff     = target - raw;
    assign packed_d = {diff[OFF_W-1], diff[ST_SHR +: MAG_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            store_q <= '0;
        end else if (load) begin
            off_q   <= diff;
            store_q <= packed_d;
        end else if (clr) begin
            off_q   <= '0;
            store_q <= '0;
        end
    end
endmodule

// File: rtl/ofc_ctrl.sv
module ofc_ctrl #(
    parameter int            RANGE_W  = 4,
    parameter logic [3:0]    RANGE_2G = 4'h3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctl_wr,
    input  logic [ofc_pkg::CTL_W-1:0]   ctl_wdata,
    input  logic                        cal_ready,
    input  logic [RANGE_W-1:0]          range_sel,
    input  logic                        err_en_notready,
    input  logic                        err_en_range,
    output logic                        busy,
    output logic                        err,
    output logic                        clr_all,
    output logic                        apply_en,
    output logic [ofc_pkg::TRIG_W-1:0]  apply_axis,
    output logic [ofc_pkg::SLOW_W-1:0]  slow_q
);
    import ofc_pkg::*;

    ofc_state_e             state, state_n;
    logic [CTL_W-1:0]       cmd_q;
    logic                   pend_q;
    logic [TRIG_W-1:0]      trig;
    logic                   trig_nz, range_ok, reject, go;

    assign trig     = cmd_q[TRIG_LO +: TRIG_W];
    assign trig_nz  = |trig;
    assign range_ok = (range_sel == RANGE_W'(RANGE_2G));
    assign reject   = trig_nz && ((!cal_ready && err_en_notready) ||
                                  (cal_ready && !range_ok && err_en_range));
    assign go       = trig_nz && cal_ready;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (ctl_wr) state_n = ST_EVAL;
            ST_EVAL: begin
                if (reject)             state_n = ST_FAULT;
                else if (cmd_q[CLR_BIT]) state_n = ST_CLEAR;
                else if (go)            state_n = ST_APPLY;
                else                    state_n = ST_IDLE;
            end
            ST_CLEAR: state_n = pend_q ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_n = ST_IDLE;
            ST_FAULT: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cmd_q  <= '0;
            pend_q <= 1'b0;
            slow_q <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && ctl_wr)
                cmd_q <= ctl_wdata;
            if (state == ST_EVAL) begin
                pend_q <= go && !reject;
                if (!reject)
                    slow_q <= cmd_q[SLOW_W-1:0];
            end
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        err        = (state == ST_FAULT);
        clr_all    = (state == ST_CLEAR);
        apply_en   = (state == ST_APPLY);
        apply_axis = trig;
    end
endmodule

// File: rtl/ofc_fast_comp.sv
module ofc_fast_comp #(
    parameter int         OFF_W    = 16,
    parameter int         ST_W     = 8,
    parameter int         ST_SHR   = 3,
    parameter int         ONE_G    = 1024,
    parameter int         RANGE_W  = 4,
    parameter logic [3:0] RANGE_2G = 4'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [7:0]         ctl_wdata,
    input  logic [5:0]         tgt_sel,
    input  logic               cal_ready,
    input  logic [RANGE_W-1:0] range_sel,
    input  logic               err_en_notready,
    input  logic               err_en_range,
    input  logic [OFF_W-1:0]   raw_x,
    input  logic [OFF_W-1:0]   raw_y,
    input  logic [OFF_W-1:0]   raw_z,
    output logic               busy,
    output logic               err,
    output logic [7:0]         ctl_rdata,
    output logic [OFF_W-1:0]   off_x,
    output logic [OFF_W-1:0]   off_y,
    output logic [OFF_W-1:0]   off_z,
    output logic [ST_W-1:0]    offreg_x,
    output logic [ST_W-1:0]    offreg_y,
    output logic [ST_W-1:0]    offreg_z
);
    import ofc_pkg::*;
    localparam int N_AX = 3;

    logic                clr_all, apply_en;
    logic [TRIG_W-1:0]   apply_axis;
    logic [SLOW_W-1:0]   slow_q;
    logic [OFF_W-1:0]    raw_a  [N_AX];
    logic [OFF_W-1:0]    off_a  [N_AX];
    logic [ST_W-1:0]     st_a   [N_AX];

    assign raw_a[0] = raw_x;
    assign raw_a[1] = raw_y;
    assign raw_a[2] = raw_z;

    ofc_ctrl #(.RANGE_W(RANGE_W), .RANGE_2G(RANGE_2G)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cal_ready(cal_ready), .range_sel(range_sel),
        .err_en_notready(err_en_notready), .err_en_range(err_en_range),
        .busy(busy), .err(err), .clr_all(clr_all), .apply_en(apply_en),
        .apply_axis(apply_axis), .slow_q(slow_q)
    );

    for (genvar a = 0; a < N_AX; a++) begin : g_axis
        logic [OFF_W-1:0] tgt;
        logic             ld;
        assign ld = apply_en && (apply_axis == TRIG_W'(a + 1));

        ofc_target_sel #(.OFF_W(OFF_W), .ONE_G(ONE_G)) u_tgt (
            .code(tgt_sel[a*TCODE_W +: TCODE_W]), .target(tgt)
        );
        ofc_axis_regs #(.OFF_W(OFF_W), .ST_W(ST_W), .ST_SHR(ST_SHR)) u_regs (
            .clk(clk), .rst_n(rst_n), .clr(clr_all), .load(ld),
            .target(tgt), .raw(raw_a[a]), .off_q(off_a[a]), .store_q(st_a[a])
        );
    end

    assign off_x    = off_a[0];
    assign off_y    = off_a[1];
    assign off_z    = off_a[2];
    assign offreg_x = st_a[0];
    assign offreg_y = st_a[1];
    assign offreg_z = st_a[2];

    always_comb begin
        ctl_rdata             = '0;
        ctl_rdata[RDY_BIT]    = cal_ready;
        ctl_rdata[SLOW_W-1:0] = slow_q;
    end
endmodule

// File: rtl/ofc_fast_comp_chk.sv
module ofc_fast_comp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        err,
    input logic [7:0]  ctl_rdata,
    input logic [15:0] off_x,
    input logic [15:0] off_y,
    input logic [15:0] off_z,
    input logic [7:0]  offreg_x,
    input logic [7:0]  offreg_y,
    input logic [7:0]  offreg_z
);
    // R9: error is a single-cycle pulse
    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    // R9: a rejected write leaves offsets untouched
    assert_err_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> ($stable(off_x) && $stable(off_y) && $stable(off_z) && $stable(ctl_rdata[2:0])));
    // R10: error only occurs inside an operation
    assert_err_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> busy);
    // R11: no change of state when idle
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(off_x) && $stable(off_y) && $stable(off_z) &&
                   $stable(offreg_x) && $stable(offreg_y) && $stable(offreg_z) &&
                   $stable(ctl_rdata[2:0])));
    // R5: storage copies track the internal offsets between operations
    assert_store_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (offreg_x == {off_x[15], off_x[9:3]} &&
                   offreg_y == {off_y[15], off_y[9:3]} &&
                   offreg_z == {off_z[15], off_z[9:3]}));
    // R2: unused readback bits stay zero
    assert_rdata_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[7:5] == 3'b000) && !ctl_rdata[3]);
endmodule

bind ofc_fast_comp ofc_fast_comp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .ctl_rdata(ctl_rdata),
    .off_x(off_x), .off_y(off_y), .off_z(off_z),
    .offreg_x(offreg_x), .offreg_y(offreg_y), .offreg_z(offreg_z)
);

// File: tb/test_ofc_fast_comp.sv
`timescale 1ns/1ps
module test_ofc_fast_comp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [5:0]  tgt_sel = '0;
    logic        cal_ready = 1'b1;
    logic [3:0]  range_sel = 4'h3;
    logic        err_en_notready = 1'b0;
    logic        err_en_range = 1'b0;
    logic [15:0] raw_x = '0, raw_y = '0, raw_z = '0;
    logic        busy, err;
    logic [7:0]  ctl_rdata;
    logic [15:0] off_x, off_y, off_z;
    logic [7:0]  offreg_x, offreg_y, offreg_z;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_off [3];
    logic [2:0]  m_slow;
    int          last_err_cnt, last_busy_cnt;
    logic [31:0] seed_dummy;

    always #2.5 clk = ~clk;

    ofc_fast_comp i_ofc_fast_comp (.*);

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_target(input logic [1:0] c);
        if (c == 2'd1) return 16'd1024;
        if (c == 2'd2) return 16'hFC00;
        return 16'd0;
    endfunction

    function automatic logic [7:0] f_store(input logic [15:0] v);
        return {v[15], v[9:3]};
    endfunction

    // reference model of one accepted write; returns whether it is rejected
    function automatic bit model(input logic [7:0] d);
        logic [1:0] t;
        bit rej;
        t = d[6:5];
        rej = (t != 0) && ((!cal_ready && err_en_notready) ||
                           (cal_ready && range_sel != 4'h3 && err_en_range));
        if (rej) return 1'b1;
        m_slow = d[2:0];
        if (d[7]) for (int a = 0; a < 3; a++) m_off[a] = '0;
        if (cal_ready && t != 0) begin
            logic [15:0] r;
            r = (t == 1) ? raw_x : (t == 2) ? raw_y : raw_z;
            m_off[t-1] = f_target(tgt_sel[(t-1)*2 +: 2]) - r;
        end
        return 1'b0;
    endfunction

    task automatic wait_done();
        last_err_cnt = 0;
        last_busy_cnt = 0;
        for (int i = 0; i < 12 && busy; i++) begin
            if (err) last_err_cnt++;
            last_busy_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic check_all(input string req);
        chk(off_x == m_off[0], req, off_x, m_off[0]);
        chk(off_y == m_off[1], req, off_y, m_off[1]);
        chk(off_z == m_off[2], req, off_z, m_off[2]);
        chk(offreg_x == f_store(m_off[0]), {req, "/R5"}, offreg_x, f_store(m_off[0]));
        chk(offreg_y == f_store(m_off[1]), {req, "/R5"}, offreg_y, f_store(m_off[1]));
        chk(offreg_z == f_store(m_off[2]), {req, "/R5"}, offreg_z, f_store(m_off[2]));
        chk(ctl_rdata == {3'b000, cal_ready, 1'b0, m_slow}, {req, "/R2"},
            ctl_rdata, {3'b000, cal_ready, 1'b0, m_slow});
    endtask

    task automatic do_write(input logic [7:0] d, input string req);
        bit rej;
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        rej = model(d);
        @(negedge clk);
        ctl_wr = 1'b0;
        chk(busy == 1'b1, "R10", busy, 1);
        wait_done();
        chk(last_busy_cnt <= 3, "R10", last_busy_cnt, 3);
        chk(last_err_cnt == (rej ? 1 : 0), {req, "/R9"}, last_err_cnt, rej ? 1 : 0);
        check_all(req);
    endtask

    initial begin
        for (int a = 0; a < 3; a++) m_off[a] = '0;
        m_slow = '0;
        seed_dummy = $urandom(32'h5EED_0F0C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0 && err == 0, "R1", {busy, err}, 0);
        check_all("R1");

        // R3/R4: each axis, each target code
        raw_x = 16'd100; raw_y = 16'hFF00; raw_z = 16'd1000;
        tgt_sel = {2'd2, 2'd1, 2'd0};
        do_write(8'h20, "R4");
        do_write(8'h40, "R3");
        do_write(8'h60, "R3");
        tgt_sel = {2'd3, 2'd3, 2'd3};
        do_write(8'h60, "R3");
        // R4: wrap modulo 2^16
        raw_x = 16'h8000; tgt_sel = 6'b000001;
        do_write(8'h20, "R4");
        // R6: clear before trigger
        raw_y = 16'd5; tgt_sel = 6'b000100;
        do_write(8'hC5, "R6");
        chk(off_x == 0 && off_z == 0, "R6", {off_x, off_z}, 0);
        do_write(8'h80, "R6");
        // R7: not ready, no error -> trigger ignored, enables apply
        cal_ready = 1'b0;
        do_write(8'h23, "R7");
        // R7: not ready with error enabled
        err_en_notready = 1'b1;
        do_write(8'hA4, "R7");
        cal_ready = 1'b1;
        // R8: range not 2g
        range_sel = 4'h5;
        do_write(8'h41, "R8");
        err_en_range = 1'b1;
        do_write(8'hC2, "R8");
        // R8: zero trigger never rejected
        do_write(8'h06, "R8");
        range_sel = 4'h3;
        // R10: second write while busy ignored
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 8'h21;
        void'(model(8'h21));
        @(negedge clk);
        ctl_wdata = 8'hE7;
        @(negedge clk);
        ctl_wr = 1'b0;
        wait_done();
        check_all("R10");

        // random mix (R4, R7, R8, R9, R11)
        for (int k = 0; k < 300; k++) begin
            raw_x = 16'($urandom); raw_y = 16'($urandom); raw_z = 16'($urandom);
            tgt_sel = 6'($urandom);
            cal_ready = ($urandom % 5) != 0;
            range_sel = (($urandom % 3) == 0) ? 4'($urandom) : 4'h3;
            err_en_notready = 1'($urandom);
            err_en_range = 1'($urandom);
            do_write(8'($urandom) & 8'hE7 | 8'($urandom % 2) << 3 & 8'h00, "R4");
            repeat (1 + $urandom % 3) @(negedge clk);
            check_all("R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule